// File: doc/BRIEF.md
# Multi-Channel Auto Conversion Sequencer

This block decides which analog input an external converter samples next, and when. Software-style configuration inputs give a channel enable mask, a conversion mode, a sequencing mode, an interval code and a start bit. Some pins can be marked as digital outputs, and those pins are never converted. When the start bit is set and both mode fields select automatic operation, the block walks through the enabled channels in rising index order. For each channel it sends a one-cycle convert request together with the channel index. It then waits for the converter's done strobe, and waits again for the programmed interval before the next request.

Each 12-bit result is written into a per-channel result slot, but only while result capture is enabled. Each slot is read as two bytes through a combinational register port. The even byte address holds the four low result bits in its upper nibble. The odd address holds the eight high bits. The enable mask is copied into an internal register only while the start bit is low. A mask change made during a run therefore takes effect only after the start bit has been cleared and set again.

Top module: `conv_seq_top`

## Requirements
- R1: After reset, `conv_req` is low and every result byte reads 0.
- R2: A request is issued only while `cfg_run` is 1, `cfg_conv_mode` is 1 and `cfg_seq_mode` is 1. Any other combination issues no requests.
- R3: Requests visit the eligible channels in ascending index order. After the highest eligible channel, the sequence wraps to the lowest one.
- R4: With interval code k, the next request leaves the block exactly `IVL_BASE << k` clock cycles after the edge at which `conv_done` is accepted.
- R5: The enable mask is captured only while `cfg_run` is 0. Mask changes made while `cfg_run` is 1 do not alter the visited channels until `cfg_run` goes low and then high again.
- R6: If no channel is eligible, no request is issued, even with all run conditions met.
- R7: A channel whose `cfg_pin_out` bit is 1 is never requested, even when its mask bit is 1.
- R8: For channel c, byte address 2c reads {result[3:0], 4'b0000} and byte address 2c+1 reads result[11:4].
- R9: A result is written into its slot only when `cfg_store_en` is 1 as `conv_done` is accepted. Otherwise the slot keeps its old value.
- R10: `conv_req` is a single-cycle pulse. Only one conversion is outstanding at a time: no new request is issued before the previous `conv_done` arrives or the run stops.
- R11: Stopping the run abandons an in-flight conversion. A `conv_done` that arrives after the stop is not stored and does not start a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_run | input | 1 | Start bit for the sequence |
| cfg_conv_mode | input | 2 | Conversion mode: 0 = stopped/manual, 1 = autonomous |
| cfg_seq_mode | input | 2 | Sequencing mode: 1 = step through the mask |
| cfg_interval | input | 2 | Interval code k; the wait is IVL_BASE << k cycles |
| cfg_chan_mask | input | NCH | Channel enable mask |
| cfg_pin_out | input | NCH | Pins used as digital outputs (excluded from conversion) |
| cfg_store_en | input | 1 | Result capture enable |
| conv_req | output | 1 | One-cycle convert request |
| conv_chan | output | $clog2(NCH) | Channel index for the request |
| conv_done | input | 1 | Conversion finished strobe |
| conv_data | input | 12 | Conversion result |
| rd_addr | input | $clog2(2*NCH) | Result byte address |
| rd_data | output | 8 | Result byte |

## Verification
The bench targets the wrap from the highest eligible channel back to the lowest. A design that restarted at channel 0 every time, or skipped the lowest channel, would produce a wrong visit list. It rewrites the mask in the middle of a run. A design that sampled the mask live would switch channels without a restart. It also measures the spacing between requests for two interval codes, which exposes an off-by-one in the countdown or a shift applied in the wrong direction. Finally, it stops a run while a conversion is in flight and checks that the late result is dropped, and it reads both bytes of each result slot. A design with the nibble or byte layout swapped, or one that kept writing with capture disabled, would show wrong bytes.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    localparam logic [1:0] CONV_MODE_AUTO = 2'd1;
    localparam logic [1:0] SEQ_MODE_AUTO  = 2'd1;
    localparam int         RES_W          = 12;
    localparam int         LO_NIB_W       = RES_W - 8;

endpackage

// File: rtl/conv_seq_pick.sv
module conv_seq_pick #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] elig,
    input  logic [CW-1:0]  start_idx,
    output logic           found,
    output logic [CW-1:0]  pick
);
    // First eligible channel at or above start_idx, wrapping round.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NCH; i++) begin
            int j;
            j = (int'(start_idx) + i) % NCH;
            if (!found && elig[j]) begin
                found = 1'b1;
                pick  = CW'(j);
            end
        end
    end

endmodule

// File: rtl/conv_seq_results.sv
module conv_seq_results
    import conv_seq_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH),
    localparam int AW = $clog2(2 * NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_chan,
    input  logic [RES_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data
);
    logic [RES_W-1:0] res_d [NCH];
    logic [RES_W-1:0] res_q [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_slot
        always_comb begin
            res_d[c] = res_q[c];
            if (wr_en && (wr_chan == CW'(c))) begin
                res_d[c] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[c] <= '0;
            end else begin
                res_q[c] <= res_d[c];
            end
        end
    end

    logic [CW-1:0]    rd_chan;
    logic [RES_W-1:0] rd_word;

    always_comb begin
        rd_chan = rd_addr[AW-1:1];
        rd_word = res_q[rd_chan];
        if (rd_addr[0]) begin
            rd_data = rd_word[RES_W-1:LO_NIB_W];
        end else begin
            rd_data = {rd_word[LO_NIB_W-1:0], {(8 - LO_NIB_W){1'b0}}};
        end
    end

endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
    import conv_seq_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int IVL_BASE = 93750,
    localparam int CW = $clog2(NCH),
    localparam int AW = $clog2(2 * NCH),
    localparam int TW = $clog2(IVL_BASE * 8 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_run,
    input  logic [1:0]       cfg_conv_mode,
    input  logic [1:0]       cfg_seq_mode,
    input  logic [1:0]       cfg_interval,
    input  logic [NCH-1:0]   cfg_chan_mask,
    input  logic [NCH-1:0]   cfg_pin_out,
    input  logic             cfg_store_en,
    output logic             conv_req,
    output logic [CW-1:0]    conv_chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data
);
    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  ptr;
        logic [CW-1:0]  chan;
        logic           req;
        logic [TW-1:0]  cnt;
        logic [NCH-1:0] mask;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic           running;
    logic [NCH-1:0] elig;
    logic           pick_found;
    logic [CW-1:0]  pick_idx;
    logic [TW-1:0]  ivl_len;
    logic           store_now;
    logic [NCH-1:0] act_mask;

    assign running  = cfg_run && (cfg_conv_mode == CONV_MODE_AUTO)
                              && (cfg_seq_mode  == SEQ_MODE_AUTO);
    assign elig     = r_q.mask & ~cfg_pin_out;
    assign ivl_len  = TW'(IVL_BASE) << cfg_interval;
    assign act_mask = r_q.mask;

    conv_seq_pick #(.NCH(NCH)) pick_i (
        .elig      (elig),
        .start_idx (r_q.ptr),
        .found     (pick_found),
        .pick      (pick_idx)
    );

    always_comb begin
        r_d       = r_q;
        r_d.req   = 1'b0;
        store_now = 1'b0;
        if (!cfg_run) begin
            r_d.mask = cfg_chan_mask;
        end
        if (!running) begin
            r_d.st  = ST_IDLE;
            r_d.ptr = '0;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (pick_found) begin
                        r_d.req  = 1'b1;
                        r_d.chan = pick_idx;
                        r_d.st   = ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (conv_done) begin
                        store_now = cfg_store_en;
                        r_d.ptr   = (r_q.chan == CW'(NCH - 1)) ? '0 : r_q.chan + CW'(1);
                        r_d.cnt   = ivl_len - TW'(1);
                        r_d.st    = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (r_q.cnt == '0) begin
                        if (pick_found) begin
                            r_d.req  = 1'b1;
                            r_d.chan = pick_idx;
                            r_d.st   = ST_BUSY;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt - TW'(1);
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_req  = r_q.req;
    assign conv_chan = r_q.chan;

    conv_seq_results #(.NCH(NCH)) res_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_now),
        .wr_chan (r_q.chan),
        .wr_data (conv_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_run,
    input logic [1:0]     cfg_conv_mode,
    input logic [1:0]     cfg_seq_mode,
    input logic [NCH-1:0] cfg_pin_out,
    input logic [NCH-1:0] act_mask,
    input logic           conv_req,
    input logic [CW-1:0]  conv_chan,
    input logic           conv_done
);
    logic           go_q;
    logic           busy_q;
    logic [NCH-1:0] elig_q;
    logic           go_now;

    assign go_now = cfg_run && (cfg_conv_mode == 2'd1) && (cfg_seq_mode == 2'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q   <= 1'b0;
            busy_q <= 1'b0;
            elig_q <= '0;
        end else begin
            go_q   <= go_now;
            elig_q <= act_mask & ~cfg_pin_out;
            if (conv_req) begin
                busy_q <= 1'b1;
            end else if (conv_done || !go_now) begin
                busy_q <= 1'b0;
            end
        end
    end

    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> go_q); // R2

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req); // R10

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> !busy_q); // R10

    AST_REQ_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> elig_q[conv_chan]); // R7

    AST_REQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (elig_q != '0)); // R6

    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_run) |-> $stable(act_mask)); // R5

endmodule

bind conv_seq_top conv_seq_chk #(.NCH(NCH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_run       (cfg_run),
    .cfg_conv_mode (cfg_conv_mode),
    .cfg_seq_mode  (cfg_seq_mode),
    .cfg_pin_out   (cfg_pin_out),
    .act_mask      (act_mask),
    .conv_req      (conv_req),
    .conv_chan     (conv_chan),
    .conv_done     (conv_done)
);

// File: tb/conv_seq_top_tb_top.sv
`timescale 1ns/1ps
module conv_seq_top_tb_top;
    localparam int NCH = 8;
    localparam int IVL = 10;
    localparam int CW  = $clog2(NCH);
    localparam int AW  = $clog2(2 * NCH);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_run = 1'b0;
    logic [1:0]      cfg_conv_mode = 2'd0;
    logic [1:0]      cfg_seq_mode = 2'd0;
    logic [1:0]      cfg_interval = 2'd0;
    logic [NCH-1:0]  cfg_chan_mask = '0;
    logic [NCH-1:0]  cfg_pin_out = '0;
    logic            cfg_store_en = 1'b0;
    logic            conv_req;
    logic [CW-1:0]   conv_chan;
    logic            conv_done = 1'b0;
    logic [11:0]     conv_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [7:0]      rd_data;

    always #4 clk = ~clk;

    conv_seq_top #(.NCH(NCH), .IVL_BASE(IVL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_conv_mode(cfg_conv_mode),
        .cfg_seq_mode(cfg_seq_mode), .cfg_interval(cfg_interval),
        .cfg_chan_mask(cfg_chan_mask), .cfg_pin_out(cfg_pin_out),
        .cfg_store_en(cfg_store_en), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Converter model and request log
    int        cyc = 0;
    int        n_req = 0;
    int        req_ch  [64];
    int        req_cyc [64];
    int        lat_cfg = 3;
    int        lat = 0;
    bit        pend = 0;
    int        pend_ch = 0;
    logic [11:0] model_val [NCH];

    always @(negedge clk) begin
        cyc++;
        conv_done = 1'b0;
        if (conv_req) begin
            if (n_req < 64) begin
                req_ch[n_req]  = int'(conv_chan);
                req_cyc[n_req] = cyc;
            end
            n_req++;
            pend    = 1;
            pend_ch = int'(conv_chan);
            lat     = lat_cfg;
        end else if (pend) begin
            if (lat <= 1) begin
                conv_done = 1'b1;
                conv_data = model_val[pend_ch];
                pend      = 0;
            end else begin
                lat--;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic read_reg(input int addr, output int val);
        @(negedge clk);
        rd_addr = AW'(addr);
        #1;
        val = int'(rd_data);
    endtask

    function automatic int exp_chan(input logic [NCH-1:0] elig, input int k);
        int cnt = 0;
        int list [NCH];
        for (int i = 0; i < NCH; i++) begin
            if (elig[i]) begin
                list[cnt] = i;
                cnt++;
            end
        end
        return (cnt == 0) ? -1 : list[k % cnt];
    endfunction

    task automatic stop_run();
        @(negedge clk);
        cfg_run = 1'b0;
        repeat (lat_cfg + 4) @(negedge clk);
    endtask

    task automatic start_auto(input logic [NCH-1:0] mask, input logic [NCH-1:0] pins,
                              input logic [1:0] ivl);
        @(negedge clk);
        cfg_chan_mask = mask;
        cfg_pin_out   = pins;
        cfg_interval  = ivl;
        cfg_conv_mode = 2'd1;
        cfg_seq_mode  = 2'd1;
        @(negedge clk);
        n_req   = 0;
        cfg_run = 1'b1;
    endtask

    task automatic wait_reqs(input int k);
        for (int t = 0; t < 3000 && n_req < k; t++) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        check("R1 conv_req after reset", int'(conv_req), 0);
        for (int a = 0; a < 2 * NCH; a++) begin
            read_reg(a, v);
            check("R1 result byte after reset", v, 0);
        end
    endtask

    task automatic t_order();
        logic [NCH-1:0] m = 8'b1010_0110;
        start_auto(m, '0, 2'd0);
        wait_reqs(8);
        stop_run();
        check("R3 request count", (n_req >= 8) ? 1 : 0, 1);
        for (int k = 0; k < 8; k++) check("R3 visit order", req_ch[k], exp_chan(m, k));
        for (int k = 0; k < 7; k++)
            check("R4 spacing code 0", req_cyc[k+1] - req_cyc[k], lat_cfg + IVL + 1);
    endtask

    task automatic t_interval();
        start_auto(8'h08, '0, 2'd2);
        wait_reqs(3);
        stop_run();
        check("R4 channel", req_ch[1], 3);
        check("R4 spacing code 2", req_cyc[1] - req_cyc[0], lat_cfg + (IVL << 2) + 1);
        check("R4 spacing code 2 again", req_cyc[2] - req_cyc[1], lat_cfg + (IVL << 2) + 1);
    endtask

    task automatic t_results();
        int lo, hi;
        for (int c = 0; c < NCH; c++) model_val[c] = 12'(12'h1A3 + c * 12'h2B7);
        cfg_store_en = 1'b1;
        start_auto(8'hFF, '0, 2'd0);
        wait_reqs(9);
        stop_run();
        for (int c = 0; c < NCH; c++) begin
            read_reg(2 * c, lo);
            read_reg(2 * c + 1, hi);
            check("R8 low byte", lo, int'({model_val[c][3:0], 4'h0}));
            check("R8 high byte", hi, int'(model_val[c][11:4]));
        end
    endtask

    task automatic t_store_off();
        int hi, lo;
        logic [11:0] old = model_val[2];
        cfg_store_en = 1'b0;
        model_val[2] = 12'hE5C;
        start_auto(8'h04, '0, 2'd0);
        wait_reqs(2);
        stop_run();
        check("R9 requests still issued", (n_req >= 2) ? 1 : 0, 1);
        read_reg(4, lo);
        read_reg(5, hi);
        check("R9 low byte kept", lo, int'({old[3:0], 4'h0}));
        check("R9 high byte kept", hi, int'(old[11:4]));
        cfg_store_en = 1'b1;
    endtask

    task automatic t_gating();
        start_auto(8'h11, '0, 2'd0);
        cfg_conv_mode = 2'd0;
        repeat (60) @(negedge clk);
        check("R2 conv mode 0 blocks", n_req, 0);
        cfg_conv_mode = 2'd1;
        cfg_seq_mode  = 2'd0;
        repeat (60) @(negedge clk);
        check("R2 seq mode 0 blocks", n_req, 0);
        cfg_seq_mode  = 2'd1;
        cfg_run       = 1'b0;
        repeat (60) @(negedge clk);
        check("R2 run low blocks", n_req, 0);
    endtask

    task automatic t_empty();
        start_auto(8'h00, '0, 2'd0);
        repeat (80) @(negedge clk);
        check("R6 empty mask", n_req, 0);
        stop_run();
        start_auto(8'h24, 8'h24, 2'd0);
        repeat (80) @(negedge clk);
        check("R6 all enabled pins are outputs", n_req, 0);
        stop_run();
    endtask

    task automatic t_pinout();
        start_auto(8'h0F, 8'h05, 2'd0);
        wait_reqs(4);
        stop_run();
        for (int k = 0; k < 4; k++) check("R7 output pins skipped", req_ch[k], exp_chan(8'h0A, k));
    endtask

    task automatic t_mask_freeze();
        start_auto(8'h01, '0, 2'd0);
        wait_reqs(1);
        cfg_chan_mask = 8'h80;
        wait_reqs(4);
        stop_run();
        for (int k = 0; k < 4; k++) check("R5 mask frozen while running", req_ch[k], 0);
        start_auto(8'h80, '0, 2'd0);
        wait_reqs(2);
        stop_run();
        check("R5 new mask after restart", req_ch[0], 7);
        check("R5 new mask after restart again", req_ch[1], 7);
    endtask

    task automatic t_stop_discard();
        int lo, hi;
        logic [11:0] old = model_val[6];
        lat_cfg      = 20;
        model_val[6] = 12'h5D2;
        start_auto(8'h40, '0, 2'd0);
        wait_reqs(1);
        repeat (3) @(negedge clk);
        cfg_run = 1'b0;
        repeat (40) @(negedge clk);
        check("R11 no further request", n_req, 1);
        check("R10 single outstanding", n_req, 1);
        read_reg(12, lo);
        read_reg(13, hi);
        check("R11 late low byte dropped", lo, int'({old[3:0], 4'h0}));
        check("R11 late high byte dropped", hi, int'(old[11:4]));
        lat_cfg = 3;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) model_val[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_order();
        t_interval();
        t_results();
        t_store_off();
        t_gating();
        t_empty();
        t_pinout();
        t_mask_freeze();
        t_stop_discard();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule